// File: doc/BRIEF.md
# Shadowed Method Register File

This block is the register store of a command processor. Methods arrive one per clock as a word index plus a 32-bit argument. Each method lands in a live bank of registers, while a second bank of the same size keeps a shadow copy. A two-bit shadow mode, loaded by writing a dedicated control index, decides how the two banks interact. A method can record its argument into the shadow bank, leave the shadow bank alone, or be replaced by the value the shadow bank already holds. That last mode lets a sequence of methods put register state back the way it was before some operation.

The value that is actually applied is the effective argument. It is forwarded one cycle after acceptance, together with strobes for the consumers that act on three particular indices: macro data, macro bind and upload data. A live register only changes when the effective argument differs from its stored value, and only then is its dirty flag set. Consumers clear dirty flags one index at a time.

Top module: `shadow_method_rf`

## Requirements
- R1: After reset every live register at index i holds 0x1000_0000 + i, except the control index 0x49, which holds 0. Every shadow register holds the same value as its live register, the shadow mode is 0 (track), every dirty flag is 0, the index error flag is 0 and `eff_valid` is 0.
- R2: In mode 0 (track) or mode 1 (track with filter), an accepted in-range method writes its argument into the shadow register at its index, and the effective argument equals the incoming argument.
- R3: In mode 2 (passthrough), the shadow bank keeps its contents, and the effective argument equals the incoming argument.
- R4: In mode 3 (replay), the incoming argument is discarded and the shadow register at the method index becomes the effective argument. The shadow bank keeps its contents.
- R5: A method at index 0x49 loads the shadow mode with bits [1:0] of the raw incoming argument, including in replay mode. Each method is handled under the mode in effect before it is applied.
- R6: The live register at the method index takes the effective argument, and its dirty flag is set, only when the effective argument differs from the stored value. Otherwise the register and the flag are left untouched.
- R7: One cycle after acceptance, `macro_data_stb` pulses for index 0x46, `macro_bind_stb` for index 0x47 and `upload_stb` for index 0x6D, with `eff_arg` carrying the effective argument. `upload_last` repeats `m_last` with the upload strobe and is 0 otherwise. At most one strobe is high at a time.
- R8: A method whose index is at or above the register count (256) changes no register, raises no `eff_valid`, and sets `idx_err`. `idx_err` stays set until reset.
- R9: `clr_valid` clears the dirty flag at `clr_idx` in the next cycle. The clear is ignored when a method in the same cycle sets that same flag.
- R10: After reset, `m_ready` is 1 from the first clock edge on. Every accepted in-range method produces `eff_valid` with its index on `eff_idx` exactly one cycle later, and no other cycle has `eff_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_valid | input | 1 | Method present |
| m_ready | output | 1 | Method can be accepted |
| m_idx | input | 12 | Method word index |
| m_arg | input | 32 | Raw method argument |
| m_last | input | 1 | Last call flag of the method |
| clr_valid | input | 1 | Dirty clear request |
| clr_idx | input | 8 | Index whose dirty flag is cleared |
| rd_idx | input | 8 | Live register read index |
| rd_data | output | 32 | Live register at `rd_idx` |
| dirty | output | 256 | Per-register dirty flags |
| mode | output | 2 | Current shadow mode |
| idx_err | output | 1 | Sticky out-of-range index flag |
| eff_valid | output | 1 | Effective argument valid |
| eff_idx | output | 8 | Index of the forwarded method |
| eff_arg | output | 32 | Effective argument |
| macro_data_stb | output | 1 | Macro data consumer strobe |
| macro_bind_stb | output | 1 | Macro bind consumer strobe |
| upload_stb | output | 1 | Upload data consumer strobe |
| upload_last | output | 1 | Last call flag for upload data |

## Verification
Two functions can meet in the same cycle. A dirty-flag clear can arrive together with a value-changing method at the same index. The bench drives `clr_valid` and `m_valid` on one edge with matching indices, and then checks that the flag stays set. Driving the same pair with differing indices must clear one flag and set the other. A second collision arises when a control write arrives in replay mode: the bench checks that the mode takes the raw argument while the live control register takes the replayed shadow value.

// File: rtl/smrf_pkg.sv
package smrf_pkg;

    typedef enum logic [1:0] {
        MODE_TRACK      = 2'd0,
        MODE_TRACK_FILT = 2'd1,
        MODE_PASS       = 2'd2,
        MODE_REPLAY     = 2'd3
    } shadow_mode_e;

    // Power-on contents of a register word
    function automatic logic [31:0] reset_word(int unsigned i, int unsigned ctrl_idx);
        if (i == ctrl_idx) return 32'h0;
        return 32'h1000_0000 + 32'(i);
    endfunction

endpackage

// File: rtl/smrf_bank.sv
module smrf_bank #(
    parameter int unsigned DEPTH    = 256,
    parameter int unsigned W        = 32,
    parameter int unsigned RD_PORTS = 1,
    parameter int unsigned CTRL_IDX = 'h49,
    localparam int unsigned AW      = $clog2(DEPTH)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [AW-1:0]                    widx,
    input  logic [W-1:0]                     wdata,
    input  logic [RD_PORTS-1:0][AW-1:0]      rd_idx,
    output logic [RD_PORTS-1:0][W-1:0]       rd_data
);
    import smrf_pkg::*;

    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[widx] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++)
                mem_q[i] <= W'(reset_word(i, CTRL_IDX));
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar g = 0; g < int'(RD_PORTS); g++) begin : g_rd
        assign rd_data[g] = mem_q[rd_idx[g]];
    end

endmodule

// File: rtl/smrf_dirty.sv
module smrf_dirty #(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [AW-1:0]    set_idx,
    input  logic             clr_en,
    input  logic [AW-1:0]    clr_idx,
    output logic [DEPTH-1:0] flags
);
    logic [DEPTH-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        // a setting write on the same index wins over the clear
        if (clr_en && !(set_en && set_idx == clr_idx)) flags_d[clr_idx] = 1'b0;
        if (set_en) flags_d[set_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

endmodule

// File: rtl/shadow_method_rf.sv
module shadow_method_rf #(
    parameter int unsigned NUM_REGS   = 256,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned IDX_W      = 12,
    parameter int unsigned CTRL_IDX   = 'h49,
    parameter int unsigned MDATA_IDX  = 'h46,
    parameter int unsigned MBIND_IDX  = 'h47,
    parameter int unsigned UPLOAD_IDX = 'h6D,
    localparam int unsigned RIDX_W    = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                m_valid,
    output logic                m_ready,
    input  logic [IDX_W-1:0]    m_idx,
    input  logic [DATA_W-1:0]   m_arg,
    input  logic                m_last,
    input  logic                clr_valid,
    input  logic [RIDX_W-1:0]   clr_idx,
    input  logic [RIDX_W-1:0]   rd_idx,
    output logic [DATA_W-1:0]   rd_data,
    output logic [NUM_REGS-1:0] dirty,
    output logic [1:0]          mode,
    output logic                idx_err,
    output logic                eff_valid,
    output logic [RIDX_W-1:0]   eff_idx,
    output logic [DATA_W-1:0]   eff_arg,
    output logic                macro_data_stb,
    output logic                macro_bind_stb,
    output logic                upload_stb,
    output logic                upload_last
);
    import smrf_pkg::*;

    typedef struct packed {
        shadow_mode_e        mode;
        logic                err;
        logic                ready;
        logic                eff_valid;
        logic [RIDX_W-1:0]   eff_idx;
        logic [DATA_W-1:0]   eff_arg;
        logic                mdata_stb;
        logic                mbind_stb;
        logic                upl_stb;
        logic                upl_last;
    } state_t;

    state_t st_d, st_q;

    logic                         acc, in_rng, sh_we, lv_we;
    logic [RIDX_W-1:0]            ridx;
    logic [DATA_W-1:0]            eff;
    logic [0:0][DATA_W-1:0]       sh_rd;
    logic [1:0][DATA_W-1:0]       lv_rd;
    logic [0:0][RIDX_W-1:0]       sh_ra;
    logic [1:0][RIDX_W-1:0]       lv_ra;

    assign ridx  = m_idx[RIDX_W-1:0];
    assign sh_ra = ridx;
    assign lv_ra = {rd_idx, ridx};

    always_comb begin
        acc    = m_valid && st_q.ready;
        in_rng = m_idx < IDX_W'(NUM_REGS);
        eff    = (st_q.mode == MODE_REPLAY) ? sh_rd[0] : m_arg;
        sh_we  = acc && in_rng &&
                 (st_q.mode == MODE_TRACK || st_q.mode == MODE_TRACK_FILT);
        lv_we  = acc && in_rng && (lv_rd[0] != eff);

        st_d           = st_q;
        st_d.ready     = 1'b1;
        st_d.eff_valid = 1'b0;
        st_d.mdata_stb = 1'b0;
        st_d.mbind_stb = 1'b0;
        st_d.upl_stb   = 1'b0;
        st_d.upl_last  = 1'b0;

        if (acc && !in_rng) st_d.err = 1'b1;

        if (acc && in_rng) begin
            st_d.eff_valid = 1'b1;
            st_d.eff_idx   = ridx;
            st_d.eff_arg   = eff;
            st_d.mdata_stb = (m_idx == IDX_W'(MDATA_IDX));
            st_d.mbind_stb = (m_idx == IDX_W'(MBIND_IDX));
            st_d.upl_stb   = (m_idx == IDX_W'(UPLOAD_IDX));
            st_d.upl_last  = (m_idx == IDX_W'(UPLOAD_IDX)) && m_last;
            // control word takes the raw argument, never the replayed one
            if (m_idx == IDX_W'(CTRL_IDX)) st_d.mode = shadow_mode_e'(m_arg[1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.mode  <= MODE_TRACK;
        end else begin
            st_q <= st_d;
        end
    end

    smrf_bank #(.DEPTH(NUM_REGS), .W(DATA_W), .RD_PORTS(2), .CTRL_IDX(CTRL_IDX)) live_i (
        .clk(clk), .rst_n(rst_n), .we(lv_we), .widx(ridx), .wdata(eff),
        .rd_idx(lv_ra), .rd_data(lv_rd)
    );

    smrf_bank #(.DEPTH(NUM_REGS), .W(DATA_W), .RD_PORTS(1), .CTRL_IDX(CTRL_IDX)) shadow_i (
        .clk(clk), .rst_n(rst_n), .we(sh_we), .widx(ridx), .wdata(m_arg),
        .rd_idx(sh_ra), .rd_data(sh_rd)
    );

    smrf_dirty #(.DEPTH(NUM_REGS)) dirty_i (
        .clk(clk), .rst_n(rst_n), .set_en(lv_we), .set_idx(ridx),
        .clr_en(clr_valid), .clr_idx(clr_idx), .flags(dirty)
    );

    assign m_ready        = st_q.ready;
    assign rd_data        = lv_rd[1];
    assign mode           = st_q.mode;
    assign idx_err        = st_q.err;
    assign eff_valid      = st_q.eff_valid;
    assign eff_idx        = st_q.eff_idx;
    assign eff_arg        = st_q.eff_arg;
    assign macro_data_stb = st_q.mdata_stb;
    assign macro_bind_stb = st_q.mbind_stb;
    assign upload_stb     = st_q.upl_stb;
    assign upload_last    = st_q.upl_last;

endmodule

// File: rtl/smrf_checker.sv
module smrf_checker #(
    parameter int unsigned NUM_REGS = 256,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned IDX_W    = 12,
    parameter int unsigned CTRL_IDX = 'h49,
    localparam int unsigned RIDX_W  = $clog2(NUM_REGS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                m_valid,
    input logic                m_ready,
    input logic [IDX_W-1:0]    m_idx,
    input logic [DATA_W-1:0]   m_arg,
    input logic [NUM_REGS-1:0] dirty,
    input logic [1:0]          mode,
    input logic                idx_err,
    input logic                eff_valid,
    input logic [RIDX_W-1:0]   eff_idx,
    input logic [DATA_W-1:0]   eff_arg,
    input logic                macro_data_stb,
    input logic                macro_bind_stb,
    input logic                upload_stb,
    input logic                upload_last
);
    logic acc, acc_in, acc_oob;
    assign acc     = m_valid && m_ready;
    assign acc_in  = acc && (m_idx <  IDX_W'(NUM_REGS));
    assign acc_oob = acc && (m_idx >= IDX_W'(NUM_REGS));

    assert_eff_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_in |=> (eff_valid && eff_idx == $past(m_idx[RIDX_W-1:0])));

    assert_no_stray_eff_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !eff_valid);

    assert_oob_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_oob |=> (idx_err && !eff_valid));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idx_err |=> idx_err);

    assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && m_idx == IDX_W'(CTRL_IDX)) |=> $stable(mode));

    assert_mode_raw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && m_idx == IDX_W'(CTRL_IDX)) |=> (mode == $past(m_arg[1:0])));

    assert_raw_forward_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_in && mode != 2'd3) |=> (eff_arg == $past(m_arg)));

    assert_strobe_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({macro_data_stb, macro_bind_stb, upload_stb}));

    assert_strobe_with_eff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (macro_data_stb || macro_bind_stb || upload_stb) |-> eff_valid);

    assert_last_only_upload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upload_last |-> upload_stb);

    assert_dirty_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> ($countones(dirty) <= $past($countones(dirty))));

endmodule

bind shadow_method_rf smrf_checker #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W), .CTRL_IDX(CTRL_IDX)
) chk_i (
    .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
    .m_idx(m_idx), .m_arg(m_arg), .dirty(dirty), .mode(mode),
    .idx_err(idx_err), .eff_valid(eff_valid), .eff_idx(eff_idx),
    .eff_arg(eff_arg), .macro_data_stb(macro_data_stb),
    .macro_bind_stb(macro_bind_stb), .upload_stb(upload_stb),
    .upload_last(upload_last)
);

// File: tb/shadow_method_rf_tb_top.sv
module shadow_method_rf_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 256;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         m_valid = 1'b0;
    logic         m_ready;
    logic [11:0]  m_idx = '0;
    logic [31:0]  m_arg = '0;
    logic         m_last = 1'b0;
    logic         clr_valid = 1'b0;
    logic [7:0]   clr_idx = '0;
    logic [7:0]   rd_idx = '0;
    logic [31:0]  rd_data;
    logic [255:0] dirty;
    logic [1:0]   mode;
    logic         idx_err, eff_valid;
    logic [7:0]   eff_idx;
    logic [31:0]  eff_arg;
    logic         macro_data_stb, macro_bind_stb, upload_stb, upload_last;

    int checks = 0;
    int fails  = 0;

    logic [31:0]  exp_live [NREG];
    logic [31:0]  exp_sh   [NREG];
    logic [255:0] exp_dirty;
    logic [1:0]   exp_mode;
    logic         exp_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    shadow_method_rf dut_i (
        .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
        .m_idx(m_idx), .m_arg(m_arg), .m_last(m_last),
        .clr_valid(clr_valid), .clr_idx(clr_idx), .rd_idx(rd_idx),
        .rd_data(rd_data), .dirty(dirty), .mode(mode), .idx_err(idx_err),
        .eff_valid(eff_valid), .eff_idx(eff_idx), .eff_arg(eff_arg),
        .macro_data_stb(macro_data_stb), .macro_bind_stb(macro_bind_stb),
        .upload_stb(upload_stb), .upload_last(upload_last)
    );

    function automatic logic [31:0] init_val(int i);
        return (i == 'h49) ? 32'h0 : 32'h1000_0000 + 32'(i);
    endfunction

    task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one method (optionally with a clear) and check against the model
    task automatic do_write(logic [11:0] idx, logic [31:0] arg, logic last,
                            logic cen, logic [7:0] cidx, string tag);
        logic       inr;
        logic [7:0] r;
        logic [31:0] eff;
        logic       chg;
        inr = idx < 12'(NREG);
        r   = idx[7:0];
        eff = arg;
        chg = 1'b0;
        if (inr) begin
            eff = (exp_mode == 2'd3) ? exp_sh[r] : arg;
            if (exp_mode < 2'd2) exp_sh[r] = arg;
            chg = exp_live[r] != eff;
            if (chg) exp_live[r] = eff;
        end else begin
            exp_err = 1'b1;
        end
        if (cen && !(chg && cidx == r)) exp_dirty[cidx] = 1'b0;
        if (chg) exp_dirty[r] = 1'b1;
        if (inr && idx == 12'h49) exp_mode = arg[1:0];

        m_valid = 1'b1; m_idx = idx; m_arg = arg; m_last = last;
        clr_valid = cen; clr_idx = cidx;
        @(negedge clk);
        m_valid = 1'b0; clr_valid = 1'b0; m_last = 1'b0;
        rd_idx = r;
        #1;
        chk("R10 eff_valid", eff_valid, inr);
        if (inr) begin
            chk("R10 eff_idx", eff_idx, r);
            chk({tag, " eff_arg"}, eff_arg, eff);
            chk({tag, " live"}, rd_data, exp_live[r]);
        end
        chk("R7 macro_data_stb", macro_data_stb, inr && idx == 12'h46);
        chk("R7 macro_bind_stb", macro_bind_stb, inr && idx == 12'h47);
        chk("R7 upload_stb", upload_stb, inr && idx == 12'h6D);
        chk("R7 upload_last", upload_last, inr && idx == 12'h6D && last);
        chk("R6 dirty", dirty, exp_dirty);
        chk("R5 mode", mode, exp_mode);
        chk("R8 idx_err", idx_err, exp_err);
    endtask

    task automatic do_clear(logic [7:0] cidx);
        exp_dirty[cidx] = 1'b0;
        clr_valid = 1'b1; clr_idx = cidx;
        @(negedge clk);
        clr_valid = 1'b0;
        #1;
        chk("R9 clear alone", dirty, exp_dirty);
    endtask

    task automatic t_reset;
        for (int i = 0; i < NREG; i++) begin
            exp_live[i] = init_val(i);
            exp_sh[i]   = init_val(i);
        end
        exp_dirty = '0; exp_mode = 2'd0; exp_err = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R10 ready", m_ready, 1'b1);
        chk("R1 dirty", dirty, '0);
        chk("R1 mode", mode, 2'd0);
        chk("R1 err", idx_err, 1'b0);
        chk("R1 eff_valid", eff_valid, 1'b0);
        for (int i = 0; i < 4; i++) begin
            automatic int k = (i == 0) ? 0 : (i == 1) ? 5 : (i == 2) ? 'h49 : 255;
            rd_idx = 8'(k);
            #1;
            chk("R1 live init", rd_data, init_val(k));
        end
        @(negedge clk);
    endtask

    task automatic t_track;
        do_write(12'd10, 32'hAAAA_0010, 1'b0, 1'b0, 8'd0, "R2");
        do_write(12'h49, 32'h0000_0001, 1'b0, 1'b0, 8'd0, "R2");
        chk("R5 filter mode", mode, 2'd1);
        do_write(12'd11, 32'hBBBB_0011, 1'b0, 1'b0, 8'd0, "R2");
    endtask

    task automatic t_pass_replay;
        do_write(12'h49, 32'h0000_0002, 1'b0, 1'b0, 8'd0, "R5");
        do_write(12'd10, 32'hCCCC_0010, 1'b0, 1'b0, 8'd0, "R3");
        chk("R3 live takes raw", rd_data, 32'hCCCC_0010);
        do_write(12'h49, 32'h0000_0003, 1'b0, 1'b0, 8'd0, "R5");
        do_write(12'd10, 32'hDEAD_0000, 1'b0, 1'b0, 8'd0, "R4");
        chk("R3 shadow kept in passthrough", eff_arg, 32'hAAAA_0010);
        chk("R4 replayed live", rd_data, 32'hAAAA_0010);
        do_write(12'd20, 32'h1234_5678, 1'b0, 1'b0, 8'd0, "R1");
        chk("R1 shadow copy of live", eff_arg, init_val(20));
        chk("R6 no dirty on equal", dirty[20], 1'b0);
        // control write while replaying: raw goes to mode, shadow to live
        do_write(12'h49, 32'h0000_0000, 1'b0, 1'b0, 8'd0, "R5");
        chk("R5 mode raw", mode, 2'd0);
        chk("R5 live ctrl replayed", rd_data, 32'h0000_0002);
    endtask

    task automatic t_nochange;
        do_clear(8'd11);
        do_write(12'd11, 32'hBBBB_0011, 1'b0, 1'b0, 8'd0, "R6");
        chk("R6 flag stays clear", dirty[11], 1'b0);
    endtask

    task automatic t_strobes;
        do_write(12'h46, 32'h0000_0A46, 1'b0, 1'b0, 8'd0, "R7");
        do_write(12'h6D, 32'h5555_0001, 1'b1, 1'b0, 8'd0, "R7");
        do_write(12'h49, 32'h0000_0003, 1'b0, 1'b0, 8'd0, "R5");
        do_write(12'h6D, 32'h0BAD_0BAD, 1'b0, 1'b0, 8'd0, "R7");
        chk("R7 upload replayed arg", eff_arg, 32'h5555_0001);
        do_write(12'h47, 32'h0BAD_0047, 1'b0, 1'b0, 8'd0, "R7");
        chk("R7 bind replayed arg", eff_arg, init_val('h47));
        do_write(12'h49, 32'h0000_0000, 1'b0, 1'b0, 8'd0, "R5");
        @(negedge clk);
        #1;
        chk("R7 strobes single cycle", {macro_data_stb, macro_bind_stb, upload_stb}, 3'b000);
        chk("R10 no eff when idle", eff_valid, 1'b0);
    endtask

    task automatic t_oob;
        do_write(12'd256, 32'h7777_7777, 1'b0, 1'b0, 8'd0, "R8");
        rd_idx = 8'd0;
        #1;
        chk("R8 aliased reg untouched", rd_data, init_val(0));
        do_write(12'hFFF, 32'h7777_7778, 1'b0, 1'b0, 8'd0, "R8");
        do_write(12'd3, 32'h3333_0003, 1'b0, 1'b0, 8'd0, "R8");
        chk("R8 err sticky", idx_err, 1'b1);
    endtask

    task automatic t_clear;
        do_write(12'd30, 32'h3030_0001, 1'b0, 1'b0, 8'd0, "R9");
        do_clear(8'd30);
        chk("R9 cleared", dirty[30], 1'b0);
        do_write(12'd30, 32'h3030_0002, 1'b0, 1'b1, 8'd30, "R9");
        chk("R9 clear loses to set", dirty[30], 1'b1);
        do_write(12'd31, 32'h3131_0001, 1'b0, 1'b1, 8'd30, "R9");
        chk("R9 clear other index", dirty[31:30], 2'b10);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_track();
        t_pass_replay();
        t_nochange();
        t_strobes();
        t_oob();
        t_clear();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule